// File: doc/BRIEF.md
# Duty-Cycle Code Interpolator

This block lets a 16-bit converter reach 18-bit average resolution. An 18-bit code splits into two parts. The upper 16 bits are a base code C. The lowest 2 bits are a fraction k. The block sends the converter an instantaneous 16-bit code that switches between C and C+1. Over each interpolation period, the share of time spent on C+1 is k quarters. A low-pass filter after the converter averages this switching into the intended fine level.

Each interpolation period is made of four equal slots. Each slot lasts `SLOT_CLKS` system clocks. C+1 is output during the first k slots and C during the rest. The default of 1250 clocks per slot gives a 5000-clock period, which is a 10 kHz repeat rate from a 50 MHz clock. A `load` strobe captures a new 18-bit code into a pending register. The pending code becomes active only when a period boundary arrives, so no period is ever output with a mixed duty.

Top module: `code_dither_interp`

## Requirements
- R1: The active 18-bit code is split so that bits [17:2] form the base code C and bits [1:0] form the fraction k. Example: code 4093 gives C=1023 with k=1, and code 4096 gives C=1024 with k=0.
- R2: On every clock, `dac_code` equals either C or C+1, and never any other value.
- R3: Within any window of one full period (4*SLOT_CLKS clocks), `dac_code` equals C+1 for exactly k*SLOT_CLKS clocks. With 2-bit k this gives 0%, 25%, 50% and 75% duty.
- R4: Within a period, C+1 is output in the first k slots, followed by C in the remaining slots.
- R5: When C is 0xFFFF, the output is held at 0xFFFF for the whole period and never wraps to zero.
- R6: A code captured during a period does not affect that period. It becomes active in the first clock of the next period.
- R7: Reset, asynchronous and active low, clears both the pending and the active code. While reset is held and after it is released, `dac_code` is 0, and the first period starts at release.
- R8: The period is exactly 4*SLOT_CLKS clocks long, and without a new load the same pattern repeats period after period.
- R9: When `load` is asserted more than once within a period, the code present at the last load is the one that becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Captures `code_in` as the pending code |
| code_in | input | 18 | Fine code: base in [17:2], fraction in [1:0] |
| dac_code | output | 16 | Instantaneous code sent to the converter |

## Verification
A wrong slot or divider count shows at the ports as a duty count off by multiples of SLOT_CLKS, or as a rise from C to C+1 spaced other than one period apart. Either error is visible within one or two periods. A swap of the code mid-period appears inside the period that is being checked, because the remaining slots stop matching the old pattern on the very next clock. A missing saturation guard puts 0x0000 on the output within the first slot after a full-scale code takes effect.

// File: rtl/interp_pkg.sv
package interp_pkg;
  // Width of the sub-LSB fraction field and the number of slots per period
  localparam int unsigned FRAC_W    = 2;
  localparam int unsigned NUM_SLOTS = 1 << FRAC_W;
  typedef logic [FRAC_W-1:0] slot_t;
endpackage

// File: rtl/interp_timer.sv
module interp_timer
  import interp_pkg::*;
#(
  parameter int unsigned SLOT_CLKS = 1250
) (
  input  logic  clk,
  input  logic  rst_n,
  output slot_t slot_idx,
  output logic  period_end
);
  logic  adv;
  slot_t slot_q, slot_d;

  generate
    if (SLOT_CLKS > 1) begin : g_div
      localparam int unsigned DIV_W = $clog2(SLOT_CLKS);
      logic [DIV_W-1:0] div_q, div_d;
      logic             slot_wrap;

      always_comb begin
        slot_wrap = (div_q == DIV_W'(SLOT_CLKS - 1));
        div_d     = slot_wrap ? '0 : div_q + DIV_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign adv = slot_wrap;

      AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(div_q) < int'(SLOT_CLKS)); // R8
    end else begin : g_nodiv
      assign adv = 1'b1;
    end
  endgenerate

  always_comb begin
    slot_d = slot_q;
    if (adv) slot_d = slot_q + slot_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_idx   = slot_q;
  assign period_end = adv && (slot_q == slot_t'(NUM_SLOTS - 1));

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(slot_q)); // R8
endmodule

// File: rtl/interp_hold.sv
module interp_hold #(
  parameter int unsigned CODE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              period_end,
  output logic [CODE_W-1:0] active_code
);
  logic [CODE_W-1:0] pend_q, pend_d;
  logic [CODE_W-1:0] act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (load)       pend_d = code_in;
    if (period_end) act_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign active_code = act_q;

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_q)); // R6
  AST_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> act_q == $past(pend_q)); // R6
  AST_LATEST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pend_q == $past(code_in)); // R9
endmodule

// File: rtl/interp_mux.sv
module interp_mux
  import interp_pkg::*;
#(
  parameter int unsigned CODE_W = 18
) (
  input  logic [CODE_W-1:0]        active_code,
  input  slot_t                    slot_idx,
  output logic [CODE_W-FRAC_W-1:0] dac_code
);
  localparam int unsigned OUT_W = CODE_W - FRAC_W;

  logic [OUT_W-1:0] base, base_up;
  slot_t            frac;
  logic             bump;

  always_comb begin
    base    = active_code[CODE_W-1:FRAC_W];
    frac    = active_code[FRAC_W-1:0];
    base_up = (base == '1) ? base : base + OUT_W'(1);
    bump    = (slot_idx < frac);
    dac_code = bump ? base_up : base;
  end
endmodule

// File: rtl/code_dither_interp.sv
module code_dither_interp
  import interp_pkg::*;
#(
  parameter int unsigned CODE_W    = 18,
  parameter int unsigned SLOT_CLKS = 1250
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [CODE_W-1:0]        code_in,
  output logic [CODE_W-FRAC_W-1:0] dac_code
);
  localparam int unsigned OUT_W = CODE_W - FRAC_W;

  slot_t             slot_idx;
  logic              period_end;
  logic [CODE_W-1:0] active_code;
  logic [OUT_W-1:0]  act_base;

  interp_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_idx   (slot_idx),
    .period_end (period_end)
  );

  interp_hold #(.CODE_W(CODE_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .code_in     (code_in),
    .period_end  (period_end),
    .active_code (active_code)
  );

  interp_mux #(.CODE_W(CODE_W)) u_mux (
    .active_code (active_code),
    .slot_idx    (slot_idx),
    .dac_code    (dac_code)
  );

  assign act_base = active_code[CODE_W-1:FRAC_W];

  AST_OUT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == act_base) ||
    ((act_base != '1) && (dac_code == act_base + OUT_W'(1)))); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_base == '1) |-> (dac_code == '1)); // R5
endmodule

// File: tb/sim_code_dither_interp.sv
module sim_code_dither_interp;
  localparam int D   = 3;
  localparam int PER = 4 * D;
  localparam int NV  = 6;
  localparam logic [17:0] VEC_CODE [NV] = '{18'd4093, 18'd4096, 18'd4094,
                                            18'd4095, 18'h00003, 18'h3FFFE};
  localparam logic [15:0] VEC_BASE [NV] = '{16'd1023, 16'd1024, 16'd1023,
                                            16'd1023, 16'd0, 16'hFFFF};
  localparam int          VEC_K    [NV] = '{1, 0, 2, 3, 3, 2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [17:0] code_in = '0;
  logic [15:0] dac_code;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  code_dither_interp #(.CODE_W(18), .SLOT_CLKS(D)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .code_in(code_in), .dac_code(dac_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
  end

  task automatic load_code(input logic [17:0] c);
    @(negedge clk);
    code_in = c;
    load    = 1'b1;
    @(negedge clk);
    load    = 1'b0;
  endtask

  initial begin
    int bad;
    int hi;
    int found;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    chk(dac_code == 16'd0, "R7 output under reset", dac_code, 0);
    rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 2 * PER; i++) begin
      @(negedge clk);
      if (dac_code != 16'd0) bad++;
    end
    chk(bad == 0, "R7 zero after release", bad, 0);

    // Table walk: R1 split, R2 pairing, R3 duty count
    for (int v = 0; v < NV; v++) begin
      logic [15:0] up;
      int exp_hi;
      load_code(VEC_CODE[v]);
      repeat (2 * PER) @(negedge clk);
      up     = (VEC_BASE[v] == 16'hFFFF) ? 16'hFFFF : VEC_BASE[v] + 16'd1;
      exp_hi = (VEC_BASE[v] == 16'hFFFF) ? 0 : VEC_K[v] * D;
      hi = 0; bad = 0;
      for (int i = 0; i < PER; i++) begin
        @(negedge clk);
        if (dac_code != VEC_BASE[v] && dac_code != up) bad++;
        else if (dac_code == up && up != VEC_BASE[v]) hi++;
      end
      chk(bad == 0, "R1/R2 only base or base+1", bad, 0);
      chk(hi == exp_hi, "R3 duty cycle count", hi, exp_hi);
    end

    // R5: full-scale code never wraps
    load_code(18'h3FFFF);
    repeat (2 * PER) @(negedge clk);
    bad = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (dac_code != 16'hFFFF) bad++;
    end
    chk(bad == 0, "R5 saturation at 0xFFFF", bad, 0);

    // Aligned test: R4 ordering, R6 deferral, R9 latest load, R8 repeat
    load_code(18'd4093);
    repeat (2 * PER) @(negedge clk);
    found = 0;
    prev = dac_code;
    for (int i = 0; i < 2 * PER && found == 0; i++) begin
      @(negedge clk);
      if (prev == 16'd1023 && dac_code == 16'd1024) found = 1;
      prev = dac_code;
    end
    chk(found == 1, "R4 period start found", found, 1);
    bad = 0;
    for (int i = 1; i < PER; i++) begin
      @(negedge clk);
      if (dac_code != ((i < D) ? 16'd1024 : 16'd1023)) bad++;
      if (i == 2 * D) begin code_in = 18'h00012; load = 1'b1; end
      if (i == 2 * D + 1) code_in = 18'h0002B;
      if (i == 2 * D + 2) load = 1'b0;
    end
    chk(bad == 0, "R6 old period completes unchanged", bad, 0);
    for (int p = 0; p < 2; p++) begin
      bad = 0;
      for (int i = 0; i < PER; i++) begin
        @(negedge clk);
        if (dac_code != ((i / D < 3) ? 16'd11 : 16'd10)) bad++;
      end
      if (p == 0) chk(bad == 0, "R4/R9 new pattern from last load", bad, 0);
      else        chk(bad == 0, "R8 pattern repeats each period", bad, 0);
    end

    // R7: reset mid-operation clears output
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(dac_code == 16'd0, "R7 reset mid-run", dac_code, 0);
    rst_n = 1'b1;
    repeat (PER) @(negedge clk);
    chk(dac_code == 16'd0, "R7 cleared code stays zero", dac_code, 0);
    finish_run();
  end
endmodule